// File: doc/BRIEF.md
# End-of-Write Status Responder

While a nonvolatile memory runs an internal byte program or erase, reads of the array have to show progress instead of stored contents. This block sits in the read path and does that. A one-cycle start pulse carries the kind of operation (byte program, sector erase or bank erase) and the most significant bit of the byte being programmed. From then on, every read strobe returns a status word. The top bit is a data-complement poll. The bit below it is a toggle that flips on each read. The internal operation time is modelled by a cycle counter whose length is set per operation kind.

When the counter runs out, busy drops. A short settling window follows. In that window the top bit already shows its final value, but the rest of the word is not yet trustworthy. After the window, reads pass the array data through unchanged. Start pulses that arrive while an operation is running are ignored. Software polls the top bit or the toggle bit until the operation is reported finished, then reads the location again once the settling window has passed.

Top module: `eow_status_resp`

## Requirements
- R1: During and directly after reset, `busy_o` and `rd_valid_o` are 0 and `rd_data_o` is all zeros.
- R2: A start pulse taken while idle raises `busy_o` on the next cycle. `busy_o` then stays high for exactly PROG_CYC cycles when `op_i`=0 (byte program), SERASE_CYC cycles when `op_i`=1 (sector erase), or BERASE_CYC cycles when `op_i`=2 (bank erase).
- R3: For a read taken while a byte program is busy, the returned bit DW-1 is the inverse of the `prog_msb_i` value captured at start.
- R4: For a read taken while an erase is busy, the returned bit DW-1 is 0.
- R5: The returned bit DW-2 is 0 on the first read after a start and inverts on each further read while busy. Cycles without a read leave it unchanged.
- R6: Bits DW-3 down to 0 read as 0 while busy and during the settling window.
- R7: For SETTLE_CYC cycles after `busy_o` falls, reads return bit DW-1 equal to the captured `prog_msb_i` for a program, or 1 for an erase. In the same window, bit DW-2 holds the last toggle value and does not flip.
- R8: Outside busy and the settling window, a read returns `array_data_i` as it was in the read cycle.
- R9: A start pulse while `busy_o` is high has no effect on the running operation or its length.
- R10: `rd_valid_o` is high exactly in the cycle after a cycle with `rd_i` high. `rd_data_o` keeps its value between reads.
- R11: A start pulse with `op_i`=3 is ignored and `busy_o` stays low.
- R12: A start pulse during the settling window ends the window and begins the new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that launches an internal operation |
| op_i | input | 2 | Operation kind: 0 program, 1 sector erase, 2 bank erase, 3 none |
| prog_msb_i | input | 1 | Top bit of the byte being programmed, sampled with start |
| array_data_i | input | DW | True array contents for the current read |
| rd_i | input | 1 | Read strobe |
| busy_o | output | 1 | Internal operation in progress |
| rd_valid_o | output | 1 | `rd_data_o` holds a new read result |
| rd_data_o | output | DW | Word returned for the last read strobe |

## Verification
The hardest situations to reach from the ports are the edges of the operation: a read that lands in the last busy cycle, the first cycle of the settling window, or the first cycle after that window closes. A start pulse that lands on one of those same boundary cycles is equally hard to hit. Directed sequences place reads on every cycle across a whole program and both erase kinds, and restart an operation from inside the settling window. A long stretch of random starts, kinds and read strobes then drives many more boundary collisions. A behavioural model, built on integer countdowns, checks every one of them.

// File: rtl/eow_pkg.sv
package eow_pkg;
   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_BANK = 2'd2,
      OP_NONE = 2'd3
   } op_e;
endpackage

// File: rtl/eow_timer.sv
module eow_timer
   import eow_pkg::*;
#(
   parameter int PROG_CYC   = 6,
   parameter int SERASE_CYC = 20,
   parameter int BERASE_CYC = 40,
   parameter int SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  op_e  op_i,
   output logic launch_o,
   output logic busy_o,
   output logic settle_o
);
   localparam int MAX_AB = (SERASE_CYC > BERASE_CYC) ? SERASE_CYC : BERASE_CYC;
   localparam int MAXC   = (PROG_CYC > MAX_AB) ? PROG_CYC : MAX_AB;
   localparam int CW     = $clog2(MAXC + 1);

   if (PROG_CYC < 1 || SERASE_CYC < 1 || BERASE_CYC < 1) begin : g_bad_dur
      $error("eow_timer: every duration must be at least one cycle");
   end
   if (SETTLE_CYC < 0) begin : g_bad_settle
      $error("eow_timer: settle length must not be negative");
   end

   logic          busy_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] load_val;
   logic          fin;

   always_comb begin
      unique case (op_i)
         OP_PROG: load_val = CW'(PROG_CYC - 1);
         OP_SECT: load_val = CW'(SERASE_CYC - 1);
         default: load_val = CW'(BERASE_CYC - 1);
      endcase
   end

   assign launch_o = start_i && !busy_q && (op_i != OP_NONE);
   assign fin      = busy_q && (cnt_q == '0);
   assign busy_o   = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (launch_o) begin
         busy_q <= 1'b1;
         cnt_q  <= load_val;
      end else if (fin) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   if (SETTLE_CYC > 0) begin : g_settle
      localparam int SW = $clog2(SETTLE_CYC + 1);
      logic [SW-1:0] s_cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)               s_cnt_q <= '0;
         else if (launch_o)        s_cnt_q <= '0;
         else if (fin)             s_cnt_q <= SW'(SETTLE_CYC);
         else if (s_cnt_q != '0)   s_cnt_q <= s_cnt_q - 1'b1;
      end
      assign settle_o = (s_cnt_q != '0);

      assert_settle_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(busy_q) |-> settle_o);
   end else begin : g_no_settle
      assign settle_o = 1'b0;
   end

   assert_rise_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start_i));
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
   assert_none_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_q && op_i == OP_NONE) |=> !busy_q);
endmodule

// File: rtl/eow_fmt.sv
module eow_fmt #(
   parameter int DW = 8
) (
   input  logic          busy_i,
   input  logic          settle_i,
   input  logic          erase_i,
   input  logic          msb_i,
   input  logic          tog_i,
   input  logic [DW-1:0] array_i,
   output logic [DW-1:0] word_o
);
   logic poll_bit;

   always_comb begin
      if (busy_i) poll_bit = erase_i ? 1'b0 : ~msb_i;
      else        poll_bit = erase_i ? 1'b1 : msb_i;
   end

   if (DW > 2) begin : g_wide
      always_comb begin
         if (busy_i || settle_i) word_o = {poll_bit, tog_i, {(DW-2){1'b0}}};
         else                    word_o = array_i;
      end
   end else begin : g_narrow
      always_comb begin
         if (busy_i || settle_i) word_o = {poll_bit, tog_i};
         else                    word_o = array_i;
      end
   end
endmodule

// File: rtl/eow_status_resp.sv
module eow_status_resp
   import eow_pkg::*;
#(
   parameter int DW         = 8,
   parameter int PROG_CYC   = 6,
   parameter int SERASE_CYC = 20,
   parameter int BERASE_CYC = 40,
   parameter int SETTLE_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    op_i,
   input  logic          prog_msb_i,
   input  logic [DW-1:0] array_data_i,
   input  logic          rd_i,
   output logic          busy_o,
   output logic          rd_valid_o,
   output logic [DW-1:0] rd_data_o
);
   if (DW < 2) begin : g_bad_dw
      $error("eow_status_resp: data width must be at least two bits");
   end

   op_e           op_c;
   logic          launch;
   logic          busy;
   logic          settle;
   logic          erase_q;
   logic          msb_q;
   logic          tog_q;
   logic [DW-1:0] word;
   logic [DW-1:0] rd_data_q;
   logic          rd_valid_q;

   assign op_c = op_e'(op_i);

   eow_timer #(
      .PROG_CYC  (PROG_CYC),
      .SERASE_CYC(SERASE_CYC),
      .BERASE_CYC(BERASE_CYC),
      .SETTLE_CYC(SETTLE_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .op_i    (op_c),
      .launch_o(launch),
      .busy_o  (busy),
      .settle_o(settle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         erase_q <= 1'b0;
         msb_q   <= 1'b0;
         tog_q   <= 1'b0;
      end else if (launch) begin
         erase_q <= (op_c != OP_PROG);
         msb_q   <= prog_msb_i;
         tog_q   <= 1'b0;
      end else if (rd_i && busy) begin
         tog_q   <= ~tog_q;
      end
   end

   eow_fmt #(.DW(DW)) u_fmt (
      .busy_i  (busy),
      .settle_i(settle),
      .erase_i (erase_q),
      .msb_i   (msb_q),
      .tog_i   (tog_q),
      .array_i (array_data_i),
      .word_o  (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         rd_valid_q <= rd_i;
         if (rd_i) rd_data_q <= word;
      end
   end

   assign busy_o     = busy;
   assign rd_valid_o = rd_valid_q;
   assign rd_data_o  = rd_data_q;

   assert_toggle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (tog_q == 1'b0));
   assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && busy && erase_q) |=> (rd_data_o[DW-1] == 1'b0));
   assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && busy && !erase_q) |=> (rd_data_o[DW-1] == ~$past(msb_q)));
   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> rd_valid_o);
   assert_hold_between_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> $stable(rd_data_o));
endmodule

// File: tb/eow_status_resp_bench.sv
module eow_status_resp_bench;
   localparam int DW = 8;
   localparam int PC = 6;
   localparam int SC = 20;
   localparam int BC = 40;
   localparam int ST = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    op_i = 2'd0;
   logic          prog_msb_i = 1'b0;
   logic [DW-1:0] array_data_i = '0;
   logic          rd_i = 1'b0;
   logic          busy_o;
   logic          rd_valid_o;
   logic [DW-1:0] rd_data_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   eow_status_resp #(.DW(DW), .PROG_CYC(PC), .SERASE_CYC(SC), .BERASE_CYC(BC),
                     .SETTLE_CYC(ST)) u_eow_status_resp (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .prog_msb_i(prog_msb_i), .array_data_i(array_data_i), .rd_i(rd_i),
      .busy_o(busy_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o));

   // behavioural reference: remaining busy and settle cycles as integers
   int          m_busy = 0;
   int          m_set  = 0;
   bit          m_tog  = 0;
   bit          m_er   = 0;
   bit          m_msb  = 0;
   bit          ev     = 0;
   bit          ev_st  = 0;
   logic [7:0]  ed     = '0;
   string       et     = "R8";

   function automatic int dur(input logic [1:0] k);
      if (k == 2'd0) return PC;
      if (k == 2'd1) return SC;
      return BC;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_set = 0; m_tog = 0; m_er = 0; m_msb = 0; ev = 0; ev_st = 0; ed = '0;
      end else begin
         ev = rd_i;
         if (rd_i) begin
            if (m_busy > 0) begin
               ed = {(m_er ? 1'b0 : ~m_msb), m_tog, 6'b0};
               et = m_er ? "R4" : "R3";
               ev_st = 1;
               m_tog = ~m_tog;
            end else if (m_set > 0) begin
               ed = {(m_er ? 1'b1 : m_msb), m_tog, 6'b0};
               et = "R7";
               ev_st = 1;
            end else begin
               ed = array_data_i;
               et = "R8";
               ev_st = 0;
            end
         end
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0) m_set = ST;
         end else begin
            if (m_set > 0) m_set--;
            if (start_i && op_i != 2'd3) begin
               m_busy = dur(op_i);
               m_set  = 0;
               m_tog  = 0;
               m_er   = (op_i != 2'd0);
               m_msb  = prog_msb_i;
            end
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(32'(busy_o), 32'(m_busy > 0), "R2");
         chk(32'(rd_valid_o), 32'(ev), "R10");
         if (ev) begin
            chk(32'(rd_data_o[7]), 32'(ed[7]), et);
            if (ev_st) begin
               chk(32'(rd_data_o[6]), 32'(ed[6]), "R5");
               chk(32'(rd_data_o[5:0]), 32'(0), "R6");
            end else begin
               chk(32'(rd_data_o[6:0]), 32'(ed[6:0]), "R8");
            end
         end
      end
   end

   task automatic drive(input bit st, input logic [1:0] k, input bit msb,
                        input bit rd, input logic [7:0] arr);
      @(negedge clk);
      start_i = st; op_i = k; prog_msb_i = msb; rd_i = rd; array_data_i = arr;
   endtask

   task automatic idle(input int n, input bit rd);
      for (int i = 0; i < n; i++) drive(0, 2'd0, 0, rd, 8'(8'h30 + i));
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(32'(busy_o), 0, "R1");
      chk(32'(rd_valid_o), 0, "R1");
      chk(32'(rd_data_o), 0, "R1");
      rst_n = 1'b1;
      idle(4, 1);                                  // R8 idle pass-through
      drive(1, 2'd0, 1, 1, 8'hA5);                 // program, msb 1, read every cycle
      idle(PC + ST + 3, 1);
      drive(1, 2'd0, 0, 0, 8'h11);                 // program, msb 0, sparse reads
      for (int i = 0; i < PC + ST + 2; i++) drive(0, 2'd0, 0, (i % 3 == 1), 8'h5A);
      drive(1, 2'd1, 0, 1, 8'h00);                 // sector erase
      idle(SC + ST + 2, 1);
      drive(1, 2'd0, 1, 0, 8'h00);                 // R9: start while busy is ignored
      idle(2, 0);
      drive(1, 2'd1, 0, 0, 8'h00);
      idle(3, 0);
      @(negedge clk);
      chk(32'(busy_o), 0, "R9");
      idle(ST + 2, 0);
      drive(1, 2'd3, 0, 0, 8'h00);                 // R11: kind 3 ignored
      @(negedge clk);
      chk(32'(busy_o), 0, "R11");
      start_i = 0;
      drive(1, 2'd2, 1, 1, 8'h00);                 // bank erase
      idle(BC, 1);
      drive(1, 2'd0, 1, 1, 8'hC3);                 // R12: restart from settle window
      @(negedge clk);
      chk(32'(busy_o), 1, "R12");
      start_i = 0;
      idle(PC + ST + 2, 1);
      for (int i = 0; i < 3000; i++)
         drive(($urandom % 15) == 0, 2'($urandom % 4), 1'($urandom % 2),
               1'($urandom % 2), 8'($urandom));
      idle(BC + ST + 2, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule